// File: doc/BRIEF.md
# Ordered Store Queue with Load Forwarding

This block sits between a simple in-order core's data memory port and the write port of a data cache. It keeps total store order. Stores are parked in a small queue and written to the cache one at a time, oldest first. A cached load does not wait behind those parked stores. When no queued store touches its word, the load reads the cache at once. When a queued store does touch its word, the requested bytes come from the youngest such store. A barrier request, and any access to uncached (I/O) space, waits until the queue has emptied.

The core presents one request per cycle on a valid/ready port. The request carries a kind, an uncached flag, a word address, data and byte enables. A load is answered one cycle after it is accepted. The cache read port is combinational: the read address is the request address, and the read data is expected in the same cycle. Commits leave on a valid/ready port, and an entry is removed only on a cycle where both are high. The depth must be a power of two and at least 2.

Top module: `store_order_buffer`

## Requirements
- R1: After reset the queue is empty: `cmValid` and `rspValid` are low, and a barrier request is accepted at once.
- R2: Queued stores leave on the commit port strictly in the order they were accepted, one entry per cycle in which `cmValid` and `cmReady` are both high.
- R3: A cached load (`reqKind` 0) whose word matches no queued store is accepted even while older stores are pending. `rspValid` rises one cycle after acceptance, and `rspData` then holds the cache word.
- R4: A cached load whose word matches queued stores returns, for every requested byte, the byte of the youngest matching entry. Enable bit b selects data bits [8b+7:8b]. Bytes that are not requested read as zero.
- R5: A cached load that requests a byte the youngest matching entry does not hold is not accepted (`reqReady` low) until that entry has committed. It then reads the cache.
- R6: A barrier (`reqKind` 2) is accepted only when the queue is empty.
- R7: A cached store (`reqKind` 1) to the same word as the youngest entry is folded into that entry when the queue holds at least two entries and that entry is not uncached. The new bytes overwrite the old ones, the enables are ORed, and no extra commit results. This also applies when the queue is full.
- R8: An uncached load or store is accepted only when the queue is empty. An uncached load raises `rdUncached`, and an uncached store is marked by `cmUncached`. While an uncached store is queued, no other request is accepted.
- R9: With all 8 entries in use, a store that cannot be folded is held off until the head commits.
- R10: While `cmValid` is high and `cmReady` is low, the commit address, data, enables and uncached flag do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| reqValid | input | 1 | Core request valid |
| reqReady | output | 1 | Request accepted this cycle when high with reqValid |
| reqKind | input | 2 | 0 load, 1 store, 2 barrier (3 treated as barrier) |
| reqUncached | input | 1 | Access targets uncached I/O space |
| reqAddr | input | 30 | Word address |
| reqData | input | 32 | Store data |
| reqBe | input | 4 | Byte enables (bytes to write or to read) |
| rspValid | output | 1 | Load answer valid |
| rspData | output | 32 | Load answer, unrequested bytes zero |
| rdValid | output | 1 | Cache read performed for an accepted load |
| rdUncached | output | 1 | The read is an uncached access |
| rdAddr | output | 30 | Cache read word address |
| rdData | input | 32 | Cache read data, same cycle |
| cmValid | output | 1 | Head entry offered to the cache |
| cmReady | input | 1 | Cache takes the head entry |
| cmAddr | output | 30 | Commit word address |
| cmData | output | 32 | Commit data |
| cmBe | output | 4 | Commit byte enables |
| cmUncached | output | 1 | Commit is an uncached store |

## Verification
The forwarding function is driven with the cache stalled, so that several stores stay queued. Loads are issued to words the queue does not hold, to a word fully covered by one entry, to a word held by two entries at once, and with narrow enables. These cases separate a cache read from a forward, the youngest entry from an older one, and masked bytes from unmasked ones. A narrow store that is folded, followed by a load over the folded bytes and a count of the commits, separates merging from appending. Loads only partly covered, barriers, uncached accesses and a full queue are each held against a stalled cache and then released. This shows that the stall lasts exactly until the queue has drained far enough.

// File: rtl/sob_pkg.sv
package sob_pkg;
  parameter int ADDR_W = 30;
  parameter int DATA_W = 32;
  localparam int BE_W = DATA_W / 8;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FENCE = 2'd2,
    OP_RSVD  = 2'd3
  } opKind_t;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
    logic [BE_W-1:0]   be;
    logic              io;
  } sbEntry_t;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic merge;
    logic loadFire;
  } sbStrobe_t;
endpackage

// File: rtl/sob_ctrl.sv
module sob_ctrl
  import sob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqKind,
  input  logic             reqUncached,
  input  logic             mergeHit,
  input  logic             fwdHit,
  input  logic             fwdCover,
  input  logic             cmReady,
  output logic             reqReady,
  output sbStrobe_t        strb,
  output logic [PTR_W-1:0] headPtr,
  output logic [PTR_W-1:0] tailPtr,
  output logic [PTR_W-1:0] youngPtr,
  output logic [CNT_W-1:0] count,
  output logic             cmValid,
  output logic             rdValid,
  output logic             rdUncached
);
  logic [PTR_W-1:0] headQ, tailQ;
  logic [CNT_W-1:0] countQ, countNext;
  logic             ioBusyQ;
  logic             empty, full, pop, canMerge, fire;
  opKind_t          kind;

  assign kind     = opKind_t'(reqKind);
  assign empty    = (countQ == '0);
  assign full     = (countQ == CNT_W'(DEPTH));
  assign cmValid  = !empty;
  assign pop      = cmValid && cmReady;
  // never fold into the entry sitting on the commit port
  assign canMerge = mergeHit && (countQ > CNT_W'(1));

  always_comb begin
    case (kind)
      OP_LOAD:  reqReady = reqUncached ? empty
                                       : (!ioBusyQ && !(fwdHit && !fwdCover));
      OP_STORE: reqReady = reqUncached ? empty
                                       : (!ioBusyQ && (canMerge || !full));
      default:  reqReady = empty;
    endcase
  end

  assign fire          = reqValid && reqReady;
  assign strb.merge    = fire && (kind == OP_STORE) && !reqUncached && canMerge;
  assign strb.push     = fire && (kind == OP_STORE) && !strb.merge;
  assign strb.loadFire = fire && (kind == OP_LOAD);
  assign rdValid       = strb.loadFire;
  assign rdUncached    = strb.loadFire && reqUncached;

  assign countNext = countQ + CNT_W'(strb.push) - CNT_W'(pop);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headQ   <= '0;
      tailQ   <= '0;
      countQ  <= '0;
      ioBusyQ <= 1'b0;
    end else begin
      if (pop)       headQ <= headQ + PTR_W'(1);
      if (strb.push) tailQ <= tailQ + PTR_W'(1);
      countQ <= countNext;
      if (strb.push && reqUncached) ioBusyQ <= 1'b1;
      else if (countNext == '0)     ioBusyQ <= 1'b0;
    end
  end

  assign headPtr  = headQ;
  assign tailPtr  = tailQ;
  assign youngPtr = tailQ - PTR_W'(1);
  assign count    = countQ;
endmodule

// File: rtl/sob_datapath.sv
module sob_datapath
  import sob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbStrobe_t         strb,
  input  logic [PTR_W-1:0]  headPtr,
  input  logic [PTR_W-1:0]  tailPtr,
  input  logic [PTR_W-1:0]  youngPtr,
  input  logic [CNT_W-1:0]  count,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [BE_W-1:0]   reqBe,
  input  logic              reqUncached,
  input  logic [DATA_W-1:0] rdData,
  output logic              mergeHit,
  output logic              fwdHit,
  output logic              fwdCover,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic [ADDR_W-1:0] cmAddr,
  output logic [DATA_W-1:0] cmData,
  output logic [BE_W-1:0]   cmBe,
  output logic              cmUncached
);
  sbEntry_t         slots [DEPTH];
  logic [DEPTH-1:0] hit;
  logic [PTR_W-1:0] sel;
  sbEntry_t         young, merged;
  logic [DATA_W-1:0] loadWord;

  // per-slot liveness and address match
  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic [PTR_W-1:0] age;
    assign age    = PTR_W'(g) - headPtr;
    assign hit[g] = (CNT_W'(age) < count) && (slots[g].addr == reqAddr) && !slots[g].io;
  end

  // youngest match wins: walk from head toward tail
  always_comb begin
    logic [PTR_W-1:0] idx;
    fwdHit = 1'b0;
    sel    = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = headPtr + PTR_W'(k);
      if (hit[idx]) begin
        fwdHit = 1'b1;
        sel    = idx;
      end
    end
  end

  assign fwdCover = ((reqBe & ~slots[sel].be) == '0);

  assign young    = slots[youngPtr];
  assign mergeHit = (count != '0) && (young.addr == reqAddr) && !young.io;

  always_comb begin
    merged    = young;
    merged.be = young.be | reqBe;
    for (int b = 0; b < BE_W; b++) begin
      if (reqBe[b]) merged.data[8*b +: 8] = reqData[8*b +: 8];
    end
  end

  always_comb begin
    for (int b = 0; b < BE_W; b++) begin
      if (!reqBe[b])                        loadWord[8*b +: 8] = 8'h00;
      else if (fwdHit && slots[sel].be[b])  loadWord[8*b +: 8] = slots[sel].data[8*b +: 8];
      else                                  loadWord[8*b +: 8] = rdData[8*b +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) begin
      slots[tailPtr] <= '{addr: reqAddr, data: reqData, be: reqBe, io: reqUncached};
    end else if (strb.merge) begin
      slots[youngPtr] <= merged;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.loadFire;
      if (strb.loadFire) rspData <= loadWord;
    end
  end

  assign cmAddr     = slots[headPtr].addr;
  assign cmData     = slots[headPtr].data;
  assign cmBe       = slots[headPtr].be;
  assign cmUncached = slots[headPtr].io;
endmodule

// File: rtl/store_order_buffer.sv
module store_order_buffer
  import sob_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic              reqUncached,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [BE_W-1:0]   reqBe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rdValid,
  output logic              rdUncached,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] rdData,
  output logic              cmValid,
  input  logic              cmReady,
  output logic [ADDR_W-1:0] cmAddr,
  output logic [DATA_W-1:0] cmData,
  output logic [BE_W-1:0]   cmBe,
  output logic              cmUncached
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  sbStrobe_t        strb;
  logic [PTR_W-1:0] headPtr, tailPtr, youngPtr;
  logic [CNT_W-1:0] count;
  logic             mergeHit, fwdHit, fwdCover;

  assign rdAddr = reqAddr;

  sob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqKind(reqKind),
    .reqUncached(reqUncached), .mergeHit(mergeHit), .fwdHit(fwdHit),
    .fwdCover(fwdCover), .cmReady(cmReady), .reqReady(reqReady), .strb(strb),
    .headPtr(headPtr), .tailPtr(tailPtr), .youngPtr(youngPtr), .count(count),
    .cmValid(cmValid), .rdValid(rdValid), .rdUncached(rdUncached)
  );

  sob_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .headPtr(headPtr), .tailPtr(tailPtr),
    .youngPtr(youngPtr), .count(count), .reqAddr(reqAddr), .reqData(reqData),
    .reqBe(reqBe), .reqUncached(reqUncached), .rdData(rdData),
    .mergeHit(mergeHit), .fwdHit(fwdHit), .fwdCover(fwdCover),
    .rspValid(rspValid), .rspData(rspData), .cmAddr(cmAddr), .cmData(cmData),
    .cmBe(cmBe), .cmUncached(cmUncached)
  );
endmodule

// File: rtl/sob_checker.sv
module sob_checker
  import sob_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqKind,
  input logic              rspValid,
  input logic              rdValid,
  input logic              rdUncached,
  input logic              cmValid,
  input logic              cmReady,
  input logic [ADDR_W-1:0] cmAddr,
  input logic [DATA_W-1:0] cmData,
  input logic [BE_W-1:0]   cmBe,
  input logic              cmUncached
);
  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!cmValid && !rspValid));

  assert_load_reply_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqKind == 2'd0) |=> rspValid);

  assert_reply_has_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(reqValid && reqReady && reqKind == 2'd0));

  assert_fence_on_empty_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && reqKind == 2'd2) |-> !cmValid);

  assert_io_read_alone_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdUncached) |-> !cmValid);

  assert_commit_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmValid && !cmReady) |=> (cmValid && $stable(cmAddr) && $stable(cmData)
                               && $stable(cmBe) && $stable(cmUncached)));
endmodule

bind store_order_buffer sob_checker u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqKind(reqKind), .rspValid(rspValid), .rdValid(rdValid),
  .rdUncached(rdUncached), .cmValid(cmValid), .cmReady(cmReady),
  .cmAddr(cmAddr), .cmData(cmData), .cmBe(cmBe), .cmUncached(cmUncached)
);

// File: tb/sim_store_order_buffer.sv
`timescale 1ns/1ps
module sim_store_order_buffer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqUncached = 1'b0, cmReady = 1'b0;
  logic [1:0]  reqKind = 2'd0;
  logic [29:0] reqAddr = '0;
  logic [31:0] reqData = '0;
  logic [3:0]  reqBe = '0;
  logic        reqReady, rspValid, rdValid, rdUncached, cmValid, cmBe0, cmUncached;
  logic [31:0] rspData, rdData, cmData;
  logic [29:0] rdAddr, cmAddr;
  logic [3:0]  cmBe;

  int nCheck = 0, nFail = 0, nCommit = 0;
  logic [31:0] mem [16];
  logic [3:0]  logAddr [64];

  always #2.5 clk = ~clk;
  assign cmBe0 = cmBe[0];

  store_order_buffer u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqKind(reqKind), .reqUncached(reqUncached), .reqAddr(reqAddr),
    .reqData(reqData), .reqBe(reqBe), .rspValid(rspValid), .rspData(rspData),
    .rdValid(rdValid), .rdUncached(rdUncached), .rdAddr(rdAddr), .rdData(rdData),
    .cmValid(cmValid), .cmReady(cmReady), .cmAddr(cmAddr), .cmData(cmData),
    .cmBe(cmBe), .cmUncached(cmUncached)
  );

  // cache model
  assign rdData = mem[rdAddr[3:0]];
  always @(posedge clk) begin
    if (rstN && cmValid && cmReady) begin
      for (int b = 0; b < 4; b++)
        if (cmBe[b]) mem[cmAddr[3:0]][8*b +: 8] <= cmData[8*b +: 8];
      logAddr[nCommit[5:0]] <= cmAddr[3:0];
      nCommit <= nCommit + 1;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCheck++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] k, input logic unc, input logic [29:0] a,
                       input logic [31:0] d, input logic [3:0] be,
                       output logic [31:0] rsp, output logic sawIo);
    int w = 0;
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqUncached = unc; reqAddr = a; reqData = d; reqBe = be;
    #1;
    while (!reqReady && w < 200) begin
      @(negedge clk); #1; w++;
    end
    if (w >= 200) begin
      nCheck++; nFail++;
      $display("FAIL handshake: actual stalled expected accepted");
    end
    sawIo = rdUncached;
    @(negedge clk);
    rsp = rspValid ? rspData : 32'hDEADBEEF;
    reqValid = 1'b0;
  endtask

  task automatic peek(input logic [1:0] k, input logic unc, input logic [29:0] a,
                      input logic [3:0] be, output logic rdy);
    @(negedge clk);
    reqValid = 1'b1; reqKind = k; reqUncached = unc; reqAddr = a; reqBe = be;
    #1;
    rdy = reqReady;
    reqValid = 1'b0;
  endtask

  task automatic drain();
    int w = 0;
    cmReady = 1'b1;
    @(negedge clk);
    while (cmValid && w < 100) begin @(negedge clk); w++; end
  endtask

  // kind, addr, data, be, expected load answer (cache stalled throughout)
  localparam logic [99:0] VEC [12] = '{
    {2'd1, 30'd2, 32'h11223344, 4'hF, 32'h0},
    {2'd1, 30'd5, 32'h55667788, 4'hF, 32'h0},
    {2'd0, 30'd7, 32'h0,        4'hF, 32'hC7D7E7F7},
    {2'd0, 30'd2, 32'h0,        4'hF, 32'h11223344},
    {2'd1, 30'd2, 32'hAABBCCDD, 4'h1, 32'h0},
    {2'd0, 30'd2, 32'h0,        4'h1, 32'h000000DD},
    {2'd1, 30'd2, 32'h0000EE00, 4'h2, 32'h0},
    {2'd0, 30'd2, 32'h0,        4'h3, 32'h0000EEDD},
    {2'd0, 30'd5, 32'h0,        4'hC, 32'h55660000},
    {2'd1, 30'd9, 32'h99999999, 4'hF, 32'h0},
    {2'd0, 30'd9, 32'h0,        4'h4, 32'h00990000},
    {2'd0, 30'd4, 32'h0,        4'h6, 32'h00D4E400}
  };

  initial begin
    repeat (20000) @(posedge clk);
    nCheck++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end

  initial begin
    logic [31:0] r;
    logic io, rdy;
    for (int i = 0; i < 16; i++)
      mem[i] = {8'(8'hC0 + i), 8'(8'hD0 + i), 8'(8'hE0 + i), 8'(8'hF0 + i)};
    repeat (3) @(negedge clk);
    check("R1 cmValid in reset", {31'd0, cmValid}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 cmValid after reset", {31'd0, cmValid}, 32'd0);
    check("R1 rspValid after reset", {31'd0, rspValid}, 32'd0);
    peek(2'd2, 1'b0, 30'd0, 4'h0, rdy);
    check("R1 barrier ready when empty", {31'd0, rdy}, 32'd1);

    // table: R3 pass, R4 forward, R7 fold
    cmReady = 1'b0;
    nCommit = 0;
    for (int i = 0; i < 12; i++) begin
      issue(VEC[i][99:98], 1'b0, VEC[i][97:68], VEC[i][67:36], VEC[i][35:32], r, io);
      if (VEC[i][99:98] == 2'd0) check("R3/R4 load answer", r, VEC[i][31:0]);
    end
    drain();
    check("R7 commits after fold", nCommit, 32'd4);
    check("R2 order 0", {28'd0, logAddr[0]}, 32'd2);
    check("R2 order 1", {28'd0, logAddr[1]}, 32'd5);
    check("R2 order 2", {28'd0, logAddr[2]}, 32'd2);
    check("R2 order 3", {28'd0, logAddr[3]}, 32'd9);
    check("R2 final word 2", mem[2], 32'h1122EEDD);
    check("R2 final word 5", mem[5], 32'h55667788);

    // R5 partial cover stalls
    cmReady = 1'b0;
    issue(2'd1, 1'b0, 30'd3, 32'h000000AB, 4'h1, r, io);
    repeat (3) begin
      peek(2'd0, 1'b0, 30'd3, 4'h3, rdy);
      check("R5 partial load held", {31'd0, rdy}, 32'd0);
    end
    cmReady = 1'b1;
    issue(2'd0, 1'b0, 30'd3, 32'h0, 4'h3, r, io);
    check("R5 load after commit", r, 32'h0000E3AB);

    // R6 barrier waits for drain
    cmReady = 1'b0;
    issue(2'd1, 1'b0, 30'd4, 32'h44444444, 4'hF, r, io);
    repeat (3) begin
      peek(2'd2, 1'b0, 30'd0, 4'h0, rdy);
      check("R6 barrier held", {31'd0, rdy}, 32'd0);
    end
    cmReady = 1'b1;
    issue(2'd2, 1'b0, 30'd0, 32'h0, 4'h0, r, io);
    check("R6 empty after barrier", {31'd0, cmValid}, 32'd0);
    check("R6 store landed", mem[4], 32'h44444444);

    // R9 full, R7 fold while full, R10 hold
    cmReady = 1'b0;
    nCommit = 0;
    for (int k = 0; k < 8; k++)
      issue(2'd1, 1'b0, 30'(k), 32'h11111111 * (k + 1), 4'hF, r, io);
    check("R10 head offered", {1'b0, cmValid, cmAddr}, 32'h40000000);
    peek(2'd1, 1'b0, 30'd8, 4'hF, rdy);
    check("R9 store held when full", {31'd0, rdy}, 32'd0);
    peek(2'd1, 1'b0, 30'd7, 4'h1, rdy);
    check("R7 fold accepted when full", {31'd0, rdy}, 32'd1);
    issue(2'd1, 1'b0, 30'd7, 32'h000000AA, 4'h1, r, io);
    repeat (2) @(negedge clk);
    check("R10 address held", {2'd0, cmAddr}, 32'd0);
    check("R10 data held", cmData, 32'h11111111);
    cmReady = 1'b1;
    issue(2'd1, 1'b0, 30'd8, 32'h12345678, 4'hF, r, io);
    drain();
    check("R9 commits", nCommit, 32'd9);
    check("R7 folded word", mem[7], 32'h888888AA);
    check("R9 late store", mem[8], 32'h12345678);

    // R8 uncached
    cmReady = 1'b0;
    issue(2'd1, 1'b0, 30'd10, 32'h0A0A0A0A, 4'hF, r, io);
    peek(2'd0, 1'b1, 30'd11, 4'hF, rdy);
    check("R8 io load held", {31'd0, rdy}, 32'd0);
    cmReady = 1'b1;
    issue(2'd0, 1'b1, 30'd11, 32'h0, 4'hF, r, io);
    check("R8 io load data", r, 32'hCBDBEBFB);
    check("R8 io flag on read", {31'd0, io}, 32'd1);
    cmReady = 1'b0;
    issue(2'd1, 1'b1, 30'd12, 32'h0C0C0C0C, 4'hF, r, io);
    @(negedge clk);
    check("R8 io store flagged", {30'd0, cmValid, cmUncached}, 32'd3);
    peek(2'd0, 1'b0, 30'd0, 4'hF, rdy);
    check("R8 later load blocked", {31'd0, rdy}, 32'd0);
    drain();
    issue(2'd0, 1'b0, 30'd12, 32'h0, 4'hF, r, io);
    check("R8 io store landed", r, 32'h0C0C0C0C);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end
endmodule